// File: doc/BRIEF.md
# Random-Byte Instruction Decoder

This block turns a stream of random bytes into instruction records for a small random-math executor. Bytes arrive one per handshake on a valid/ready input. A lead byte is split into an operation code, a destination index and a source index. Rotations take one more byte, whose sign selects the direction. Additions take four more bytes, which form a 32-bit constant. Each finished instruction leaves as one registered record on a valid/ready output. While a record waits there, the input stalls.

Two filters run on the way out. First, an ADD, SUB or XOR whose source and destination are the same register gets register 8 as its source instead. Second, a rotation is dropped when the last record written to the same destination was itself a rotation. A dropped rotation uses up its bytes and is not retried.

A sticky flag reports whether any emitted record has used register 8 as its source. A flush input clears the flag and the rotation history, abandons any half-read instruction and drops a pending record.

Top module: `rmath_byte_decoder`

## Requirements
- R1: Bits [2:0] of a lead byte pick the operation. Values 0, 1 and 2 give MUL, 3 gives ADD, 4 gives SUB, 5 gives a rotation and 6 or 7 give XOR. The record encodes operations on `out_op` as MUL=0, ADD=1, SUB=2, ROR=3, ROL=4, XOR=5.
- R2: The destination index is taken from lead-byte bits [4:3]. The source index is taken from lead-byte bits [7:5] and is zero-extended onto the 4-bit `out_src`.
- R3: A rotation reads one extra byte. If bit 7 of that byte is 0 the record is ROR (code 3); if it is 1 the record is ROL (code 4).
- R4: For ADD, SUB or XOR, when the 3-bit source field equals the zero-extended destination, `out_src` is 8. MUL and rotations are never redirected.
- R5: An ADD reads four extra bytes, and the first of them is the least significant byte of `out_imm`. Every other operation emits `out_imm` = 0.
- R6: A rotation is discarded, and no record is emitted, when the last record emitted for the same destination was a rotation. The bytes of a discarded candidate are consumed and never read again as a lead byte.
- R7: Every emitted record updates its destination's rotation history. A non-rotation clears it, so a later rotation on that destination is emitted.
- R8: While `out_valid` is high and `out_ready` is low, the record holds steady. `in_ready` is low whenever `out_valid` is high.
- R9: `uses_r8` goes high in the same cycle that a record with `out_src` = 8 appears. It then stays high until flush or reset.
- R10: A flush cycle clears the rotation history and `uses_r8`, discards a partly read instruction and drops any pending record. The byte after the flush is treated as a lead byte.
- R11: After reset, `out_valid` and `uses_r8` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears history, partial instruction and pending record |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Random byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_op | output | 3 | Operation code (R1 encoding) |
| out_dst | output | 2 | Destination register index |
| out_src | output | 4 | Source register index, 0 to 8 |
| out_imm | output | 32 | Constant for ADD, zero otherwise |
| uses_r8 | output | 1 | Sticky: some record used register 8 as source |

## Verification
The bench sends a second rotation on the same destination, followed by a plain instruction. A decoder that failed to drop the rotation would emit an extra record. One that reused the dropped direction byte as a lead byte would emit a wrong record. The bench also aims at the self-source cases for every operation: redirecting MUL, or missing a redirect for XOR, shows up as a wrong `out_src`. A flush in the middle of an ADD constant checks that leftover constant bytes are not joined onto the next instruction. The flag-clearing case (a rotation, a flush, then a rotation on the same destination) checks that the flush really forgets the history. Random streams run under output backpressure, so a decoder that took input while a record was pending would lose or corrupt records.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
  localparam int BYTE_W     = 8;
  localparam int FUNC_W     = 3;
  localparam int DST_W      = 2;
  localparam int SRC_W      = 3;
  localparam int NUM_DST    = 1 << DST_W;
  localparam int OUT_SRC_W  = 4;
  localparam int ALIAS_IDX  = 8;

  typedef enum logic [2:0] {
    OP_MUL = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4,
    OP_XOR = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_LEAD,
    ST_DIR,
    ST_IMM,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/rmd_lead_decode.sv
module rmd_lead_decode
  import rmd_pkg::*;
(
  input  logic [BYTE_W-1:0]    lead,
  output op_e                  base_op,
  output logic                 is_rot,
  output logic                 is_add,
  output logic [DST_W-1:0]     dst,
  output logic [OUT_SRC_W-1:0] src
);
  logic [FUNC_W-1:0] func;
  logic [SRC_W-1:0]  raw_src;
  logic              self_ref;

  always_comb begin
    func    = lead[FUNC_W-1:0];
    dst     = lead[FUNC_W +: DST_W];
    raw_src = lead[FUNC_W+DST_W +: SRC_W];
    is_rot  = 1'b0;
    is_add  = 1'b0;
    case (func)
      3'd0, 3'd1, 3'd2: base_op = OP_MUL;
      3'd3: begin base_op = OP_ADD; is_add = 1'b1; end
      3'd4: base_op = OP_SUB;
      3'd5: begin base_op = OP_ROR; is_rot = 1'b1; end
      default: base_op = OP_XOR;
    endcase
    self_ref = (base_op == OP_ADD || base_op == OP_SUB || base_op == OP_XOR) &&
               (raw_src == {{(SRC_W-DST_W){1'b0}}, dst});
    src = self_ref ? OUT_SRC_W'(ALIAS_IDX) : {{(OUT_SRC_W-SRC_W){1'b0}}, raw_src};
  end
endmodule

// File: rtl/rmd_rot_history.sv
module rmd_rot_history #(
  parameter int NUM_ENT = 4,
  localparam int IW = $clog2(NUM_ENT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_rot,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_rot
);
  logic [NUM_ENT-1:0] flags;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || clr)
        flags[g] <= 1'b0;
      else if (wr_en && wr_idx == IW'(g))
        flags[g] <= wr_rot;
    end
  end

  assign rd_rot = flags[rd_idx];
endmodule

// File: rtl/rmd_imm_collect.sv
module rmd_imm_collect #(
  parameter int NBYTES = 4,
  parameter int BW     = 8,
  localparam int W     = NBYTES * BW,
  localparam int CW    = $clog2(NBYTES) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          shift_en,
  input  logic [BW-1:0] byte_in,
  output logic [W-1:0]  next_value,
  output logic          last
);
  logic [W-1:0]  value;
  logic [CW-1:0] cnt;

  assign next_value = {byte_in, value[W-1:BW]};
  assign last       = (cnt == CW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      value <= '0;
      cnt   <= '0;
    end else if (shift_en) begin
      value <= next_value;
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rmath_byte_decoder.sv
module rmath_byte_decoder
  import rmd_pkg::*;
#(
  parameter int IMM_BYTES = 4,
  localparam int IMM_W    = IMM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [BYTE_W-1:0]    in_byte,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2:0]           out_op,
  output logic [DST_W-1:0]     out_dst,
  output logic [OUT_SRC_W-1:0] out_src,
  output logic [IMM_W-1:0]     out_imm,
  output logic                 uses_r8
);
  st_e                  st;
  logic                 acc;
  op_e                  dec_op;
  logic                 dec_rot, dec_add;
  logic [DST_W-1:0]     dec_dst, hold_dst;
  logic [OUT_SRC_W-1:0] dec_src, hold_src;
  logic                 hist_rot;
  logic [IMM_W-1:0]     imm_next;
  logic                 imm_last;
  logic                 emit;
  op_e                  emit_op;
  logic [DST_W-1:0]     emit_dst;
  logic [OUT_SRC_W-1:0] emit_src;
  logic [IMM_W-1:0]     emit_imm;

  assign in_ready = (st != ST_HOLD);
  assign acc      = in_valid && in_ready;

  rmd_lead_decode u_dec (
    .lead    (in_byte),
    .base_op (dec_op),
    .is_rot  (dec_rot),
    .is_add  (dec_add),
    .dst     (dec_dst),
    .src     (dec_src)
  );

  rmd_rot_history #(.NUM_ENT(NUM_DST)) u_hist (
    .clk    (clk),
    .rst    (rst),
    .clr    (flush),
    .wr_en  (emit && !flush),
    .wr_idx (emit_dst),
    .wr_rot (emit_op == OP_ROR || emit_op == OP_ROL),
    .rd_idx (hold_dst),
    .rd_rot (hist_rot)
  );

  rmd_imm_collect #(.NBYTES(IMM_BYTES), .BW(BYTE_W)) u_imm (
    .clk        (clk),
    .rst        (rst),
    .start      (st == ST_LEAD && acc && dec_add),
    .shift_en   (st == ST_IMM && acc),
    .byte_in    (in_byte),
    .next_value (imm_next),
    .last       (imm_last)
  );

  always_comb begin
    emit     = 1'b0;
    emit_op  = dec_op;
    emit_dst = dec_dst;
    emit_src = dec_src;
    emit_imm = '0;
    case (st)
      ST_LEAD: emit = acc && !dec_rot && !dec_add;
      ST_DIR: begin
        emit     = acc && !hist_rot;
        emit_op  = in_byte[BYTE_W-1] ? OP_ROL : OP_ROR;
        emit_dst = hold_dst;
        emit_src = hold_src;
      end
      ST_IMM: begin
        emit     = acc && imm_last;
        emit_op  = OP_ADD;
        emit_dst = hold_dst;
        emit_src = hold_src;
        emit_imm = imm_next;
      end
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st        <= ST_LEAD;
      hold_dst  <= '0;
      hold_src  <= '0;
      out_valid <= 1'b0;
      out_op    <= '0;
      out_dst   <= '0;
      out_src   <= '0;
      out_imm   <= '0;
      uses_r8   <= 1'b0;
    end else begin
      case (st)
        ST_LEAD: if (acc) begin
          hold_dst <= dec_dst;
          hold_src <= dec_src;
          if (dec_rot)      st <= ST_DIR;
          else if (dec_add) st <= ST_IMM;
          else              st <= ST_HOLD;
        end
        ST_DIR:  if (acc) st <= hist_rot ? ST_LEAD : ST_HOLD;
        ST_IMM:  if (acc && imm_last) st <= ST_HOLD;
        default: if (out_ready) begin
          st        <= ST_LEAD;
          out_valid <= 1'b0;
        end
      endcase
      if (emit) begin
        out_valid <= 1'b1;
        out_op    <= emit_op;
        out_dst   <= emit_dst;
        out_src   <= emit_src;
        out_imm   <= emit_imm;
        if (emit_src == OUT_SRC_W'(ALIAS_IDX)) uses_r8 <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmd_checker.sv
module rmd_checker #(
  parameter int IMM_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_op,
  input logic [1:0]       out_dst,
  input logic [3:0]       out_src,
  input logic [IMM_W-1:0] out_imm,
  input logic             uses_r8
);
  a_r1_op_code_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_op <= 3'd5);

  a_r8_record_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !flush) |=>
      (out_valid && $stable(out_op) && $stable(out_dst) &&
       $stable(out_src) && $stable(out_imm)));

  a_r8_input_stalled: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r4_no_self_source: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (out_op == 3'd1 || out_op == 3'd2 || out_op == 3'd5)) |->
      (out_src != {2'b00, out_dst}));

  a_r5_imm_only_add: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op != 3'd1) |-> (out_imm == '0));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (uses_r8 && !flush) |=> uses_r8);

  a_r9_flag_follows_record: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_src == 4'd8) |-> uses_r8);

  a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!out_valid && !uses_r8));
endmodule

bind rmath_byte_decoder rmd_checker #(.IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_op    (out_op),
  .out_dst   (out_dst),
  .out_src   (out_src),
  .out_imm   (out_imm),
  .uses_r8   (uses_r8)
);

// File: tb/tb_rmath_byte_decoder.sv
module tb_rmath_byte_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_op;
  logic [1:0]  out_dst;
  logic [3:0]  out_src;
  logic [31:0] out_imm;
  logic        uses_r8;

  always #10 clk = ~clk;

  rmath_byte_decoder dut (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_dst(out_dst), .out_src(out_src),
    .out_imm(out_imm), .uses_r8(uses_r8)
  );

  logic [40:0] exp_q[$];
  string       tag_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [3:0]  m_rot = 4'h0;
  logic        m_r8 = 1'b0;
  logic [31:0] rng = 32'h1234_5678;
  logic [15:0] bp_lfsr = 16'hACE1;
  int          bp_mode = 0;
  bit          done = 1'b0;

  function automatic logic [7:0] mk(input int s, input int d, input int f);
    return {3'(s), 2'(d), 3'(f)};
  endfunction

  task automatic check(input string tag, input logic [40:0] act, input logic [40:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Reference model built from the requirement text
  task automatic issue(input logic [7:0] lead, input logic [31:0] ext, input string tag);
    logic [2:0] f;
    logic [1:0] d;
    logic [2:0] s;
    logic [2:0] op;
    logic [3:0] src;
    logic [31:0] imm;
    logic rot, add, keep;
    f = lead[2:0]; d = lead[4:3]; s = lead[7:5];
    rot = (f == 3'd5);
    add = (f == 3'd3);
    if (f <= 3'd2)      op = 3'd0;
    else if (add)       op = 3'd1;
    else if (f == 3'd4) op = 3'd2;
    else if (rot)       op = ext[7] ? 3'd4 : 3'd3;
    else                op = 3'd5;
    if ((op == 3'd1 || op == 3'd2 || op == 3'd5) && s == {1'b0, d}) src = 4'd8;
    else src = {1'b0, s};
    imm  = add ? ext : 32'h0;
    keep = !(rot && m_rot[d]);
    if (keep) begin
      exp_q.push_back({op, d, src, imm});
      tag_q.push_back(tag);
      m_rot[d] = rot;
      if (src == 4'd8) m_r8 = 1'b1;
    end
    send_byte(lead);
    if (rot) send_byte(ext[7:0]);
    if (add) begin
      for (int k = 0; k < 4; k++) send_byte(ext[8*k +: 8]);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      if (exp_q.size() == 0 && !out_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    m_rot = 4'h0;
    m_r8  = 1'b0;
    exp_q.delete();
    tag_q.delete();
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      bp_lfsr   = {bp_lfsr[14:0], bp_lfsr[15] ^ bp_lfsr[13] ^ bp_lfsr[12] ^ bp_lfsr[10]};
      out_ready = (bp_mode == 0) ? 1'b1 : bp_lfsr[0];
      if (out_valid && out_ready && !flush) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R6: actual unexpected record %h expected none",
                   {out_op, out_dst, out_src, out_imm});
        end else begin
          logic [40:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {out_op, out_dst, out_src, out_imm}, e);
          check("R8 stall", {40'h0, in_ready}, 41'h0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset", {38'h0, out_valid, in_ready, uses_r8}, {38'h0, 3'b010});

    // R1 and R2: every operation field, varied fields
    for (int f = 0; f < 8; f++) begin
      issue(mk((f + 3) % 8, f % 4, f), 32'h0000_0000 + 32'(f) * 32'h0101_0101, "R1 R2 field map");
      drain();
    end

    // R4: self-source per operation
    issue(mk(2, 2, 0), 0, "R4 mul not redirected");
    issue(mk(1, 1, 3), 32'hCAFE_F00D, "R4 add redirected");
    issue(mk(3, 3, 4), 0, "R4 sub redirected");
    issue(mk(0, 0, 7), 0, "R4 xor redirected");
    issue(mk(5, 1, 6), 0, "R4 high source kept");
    drain();
    check("R9 flag set", {40'h0, uses_r8}, {40'h0, m_r8});

    // R5: immediate byte order
    issue(mk(6, 2, 3), 32'h1234_5678, "R5 little endian");
    issue(mk(7, 3, 3), 32'hFF00_00FF, "R5 edge bytes");
    drain();

    // R3, R6, R7: rotation direction and discard
    do_flush();
    check("R10 flag cleared", {40'h0, uses_r8}, 41'h0);
    issue(mk(1, 0, 5), 32'h0000_0000, "R3 ror on zero");
    issue(mk(2, 0, 5), 32'h0000_0080, "R6 second rotation dropped");
    issue(mk(4, 0, 0), 0, "R6 byte not reused");
    issue(mk(3, 0, 5), 32'h0000_00FF, "R7 rotation after mul");
    issue(mk(5, 1, 5), 32'h0000_007F, "R3 ror at 7f");
    issue(mk(6, 2, 5), 32'h0000_0080, "R3 rol at 80");
    issue(mk(7, 2, 5), 32'h0000_0001, "R6 dropped dst2");
    issue(mk(0, 1, 7), 0, "R7 xor clears history");
    issue(mk(0, 1, 5), 32'h0000_0090, "R7 rotation allowed again");
    drain();

    // R10: flush forgets rotation history
    issue(mk(1, 3, 5), 0, "R10 rotation before flush");
    drain();
    do_flush();
    issue(mk(2, 3, 5), 32'h0000_00C0, "R10 rotation after flush");
    drain();

    // R10: flush in the middle of an immediate
    send_byte(mk(0, 2, 3));
    send_byte(8'hAA);
    send_byte(8'hBB);
    do_flush();
    issue(mk(1, 2, 4), 0, "R10 partial dropped");
    drain();

    // R10: flush drops a pending record
    bp_mode = 2;
    out_ready = 1'b0;
    send_byte(mk(3, 1, 0));
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check("R10 pending dropped", {40'h0, out_valid}, 41'h0);
    m_rot = 4'h0; m_r8 = 1'b0;
    bp_mode = 0;

    // R8: random stream under backpressure
    bp_mode = 1;
    for (int n = 0; n < 400; n++) begin
      logic [7:0] lead;
      next_rng();
      lead = rng[7:0];
      next_rng();
      issue(lead, rng, "R8 random stream");
    end
    drain();
    bp_mode = 0;
    check("R9 flag after stream", {40'h0, uses_r8}, {40'h0, m_r8});
    check("R6 nothing left", 41'(exp_q.size()), 41'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule